// File: doc/BRIEF.md
# Single-Wire UART Register Node

This block is a register-access endpoint on a half-duplex serial line where one pin carries traffic in both directions. A host sends two kinds of datagram: a short read request and a long write datagram. The node assembles incoming bytes, checks the leading sync byte, its own node address and a trailing CRC8. When all checks pass, it either pulses a register write strobe with address and data, or fetches a register value and answers with a long reply datagram. The reply goes out after a programmable pause. During the reply, the node drives the shared pin through an output enable.

Bit timing comes from a divisor input. Each bit is 16 oversampling ticks long, and each tick lasts `baud_div` clock cycles. The receiver samples every bit at its centre. If the line stays quiet for a long time between start bits, datagram assembly returns to its first byte. After reset, the node ignores traffic until the line has been idle for a minimum time.

Top module: `swu_node`

## Requirements
- R1: The first byte of every datagram must equal 0x05 (pattern 1,0,1,0 in the low nibble, upper bits zero). Any other first byte is discarded, and assembly stays at byte 0.
- R2: A write datagram is 8 bytes: 0x05, node address, a command byte with bit 7 = 1 and the register address in bits 6..0, four data bytes from most significant down, then CRC8. When it is valid, `wr_en` pulses for exactly one cycle, with `reg_addr` and `wr_data` holding the datagram's fields.
- R3: A read request is 4 bytes: 0x05, node address, a command byte with bit 7 = 0 and the register address, then CRC8. When it is valid, `rd_en` pulses once with `reg_addr` set. The node then answers with 8 bytes: 0x05, 0xFF, the address with bit 7 clear, the four bytes of `rd_data` from most significant down, then CRC8.
- R4: The CRC8 uses polynomial 0x07 with the register starting at 0x00. It consumes each byte from bit 0 to bit 7, and covers every byte before the CRC byte. A datagram whose CRC byte does not match is dropped: no strobe and no reply.
- R5: A datagram whose address byte differs from `node_addr` causes no strobe and no reply.
- R6: If more than 63 bit times pass between two start bits, assembly restarts at byte 0. A gap of 63 bit times or less keeps the partial datagram.
- R7: After reset, no datagram is accepted until the line has been idle for 12 bit times.
- R8: The reply's start bit begins between D·16−8 and D·16+24 oversampling ticks after the request's final stop bit ends, where D = `reply_delay`.
- R9: `pin_oe` is high only while the reply is being sent, and it covers all 8 bytes. Each reply byte is 1 start bit (0), 8 data bits LSB first and 1 stop bit (1). While `pin_oe` is low, `pin_out` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| baud_div | input | 16 | Clock cycles per oversampling tick (16 ticks per bit) |
| node_addr | input | 8 | Address this node answers to |
| reply_delay | input | 8 | Pause before the reply, in bit times |
| rd_data | input | 32 | Register value for the address on `reg_addr`, sampled the cycle after `rd_en` |
| pin_in | input | 1 | Shared serial line as seen by the node |
| pin_out | output | 1 | Serial data driven onto the line |
| pin_oe | output | 1 | Drive enable for `pin_out` |
| reg_addr | output | 7 | Register address of the current datagram |
| wr_en | output | 1 | One-cycle register write strobe |
| wr_data | output | 32 | Write data, valid with `wr_en` |
| rd_en | output | 1 | One-cycle register read strobe |

## Verification
With a divisor of 1, a bit lasts 16 cycles. A strobe is due about four cycles before the end of the last stop bit the bench drives, because the receiver accepts the byte at the stop-bit centre and then adds sync and register stages. The bench therefore checks strobe counts and fields four cycles after the end of that stop bit. The reply start is due D bit times later, give or take one bit of phase of the free-running bit counter. The bench counts cycles from the end of the request and accepts the window stated in R8. It then samples each reply bit eight cycles after the start edge it sees and every 16 cycles after that, and checks the enable 12 cycles past the last stop-bit centre.

// File: rtl/swu_pkg.sv
package swu_pkg;
  localparam logic [7:0] SYNC_BYTE   = 8'h05;
  localparam logic [7:0] MASTER_BYTE = 8'hFF;

  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_st_t;
  typedef enum logic [1:0] {N_RECV, N_WAIT, N_SEND} node_st_t;

  // CRC8, polynomial 0x07, byte consumed from bit 0 upward
  function automatic logic [7:0] crc8_lsb(input logic [7:0] crc, input logic [7:0] b);
    logic [7:0] c;
    c = crc;
    for (int i = 0; i < 8; i++) begin
      if (c[7] ^ b[i]) c = {c[6:0], 1'b0} ^ 8'h07;
      else             c = {c[6:0], 1'b0};
    end
    return c;
  endfunction
endpackage

// File: rtl/swu_baud.sv
module swu_baud #(
  parameter int DIV_W = 16,
  parameter int OVS   = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div,
  output logic             tick,
  output logic             bit_stb
);
  localparam int SUB_W = $clog2(OVS);

  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic [SUB_W-1:0] sub_q, sub_d;

  always_comb begin
    tick    = ({1'b0, cnt_q} + 1'b1) >= {1'b0, div};
    cnt_d   = tick ? '0 : cnt_q + 1'b1;
    sub_d   = sub_q;
    bit_stb = 1'b0;
    if (tick) begin
      bit_stb = (sub_q == SUB_W'(OVS - 1));
      sub_d   = bit_stb ? '0 : sub_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sub_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      sub_q <= sub_d;
    end
  end
endmodule

// File: rtl/swu_rx.sv
module swu_rx (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       line,
  output logic       vld,
  output logic [7:0] data,
  output logic       busy,
  output logic       start
);
  import swu_pkg::*;

  rx_st_t     st_q, st_d;
  logic [3:0] t_q, t_d;
  logic [2:0] n_q, n_d;
  logic [7:0] sh_q, sh_d;
  logic       vld_q, vld_d;

  always_comb begin
    st_d  = st_q;
    t_d   = t_q;
    n_d   = n_q;
    sh_d  = sh_q;
    vld_d = 1'b0;
    start = 1'b0;
    case (st_q)
      RX_IDLE: if (!line) begin
        st_d = RX_START;
        t_d  = '0;
      end
      RX_START: if (tick) begin
        t_d = t_q + 1'b1;
        if (t_q == 4'd7) begin
          t_d   = '0;
          n_d   = '0;
          start = !line;
          st_d  = line ? RX_IDLE : RX_DATA;
        end
      end
      RX_DATA: if (tick) begin
        t_d = t_q + 1'b1;
        if (t_q == 4'd15) begin
          sh_d = {line, sh_q[7:1]};
          n_d  = n_q + 1'b1;
          if (n_q == 3'd7) st_d = RX_STOP;
        end
      end
      RX_STOP: if (tick) begin
        t_d = t_q + 1'b1;
        if (t_q == 4'd15) begin
          st_d  = RX_IDLE;
          vld_d = line;
        end
      end
      default: st_d = RX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= RX_IDLE;
      t_q   <= '0;
      n_q   <= '0;
      sh_q  <= '0;
      vld_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      t_q   <= t_d;
      n_q   <= n_d;
      sh_q  <= sh_d;
      vld_q <= vld_d;
    end
  end

  assign vld  = vld_q;
  assign data = sh_q;
  assign busy = (st_q != RX_IDLE);
endmodule

// File: rtl/swu_tx.sv
module swu_tx (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       go,
  input  logic [7:0] data,
  output logic       txd,
  output logic       busy,
  output logic       done
);
  logic [9:0] sh_q, sh_d;
  logic [3:0] t_q, t_d, b_q, b_d;
  logic       busy_q, busy_d, done_q, done_d;

  always_comb begin
    sh_d   = sh_q;
    t_d    = t_q;
    b_d    = b_q;
    busy_d = busy_q;
    done_d = 1'b0;
    if (!busy_q) begin
      if (go) begin
        sh_d   = {1'b1, data, 1'b0};
        busy_d = 1'b1;
        t_d    = '0;
        b_d    = '0;
      end
    end else if (tick) begin
      t_d = t_q + 1'b1;
      if (t_q == 4'd15) begin
        if (b_q == 4'd9) begin
          busy_d = 1'b0;
          done_d = 1'b1;
        end else begin
          sh_d = {1'b1, sh_q[9:1]};
          b_d  = b_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '1;
      t_q    <= '0;
      b_q    <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      sh_q   <= sh_d;
      t_q    <= t_d;
      b_q    <= b_d;
      busy_q <= busy_d;
      done_q <= done_d;
    end
  end

  assign txd  = busy_q ? sh_q[0] : 1'b1;
  assign busy = busy_q;
  assign done = done_q;
endmodule

// File: rtl/swu_node.sv
module swu_node #(
  parameter int DIV_W     = 16,
  parameter int DLY_W     = 8,
  parameter int ADDR_W    = 7,
  parameter int DATA_W    = 32,
  parameter int GAP_BITS  = 63,
  parameter int IDLE_BITS = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  baud_div,
  input  logic [7:0]        node_addr,
  input  logic [DLY_W-1:0]  reply_delay,
  input  logic [DATA_W-1:0] rd_data,
  input  logic              pin_in,
  output logic              pin_out,
  output logic              pin_oe,
  output logic [ADDR_W-1:0] reg_addr,
  output logic              wr_en,
  output logic [DATA_W-1:0] wr_data,
  output logic              rd_en
);
  import swu_pkg::*;

  localparam int NB    = DATA_W / 8;
  localparam int LAST  = 3 + NB;               // index of the CRC byte in a long datagram
  localparam int IDX_W = $clog2(LAST + 1);
  localparam int GAP_W = $clog2(GAP_BITS + 2);
  localparam int IDL_W = $clog2(IDLE_BITS + 1);

  logic [1:0] rs_q, ps_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_core_n = rs_q[1];

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) ps_q <= 2'b11;
    else             ps_q <= {ps_q[0], pin_in};
  end

  logic tick, bit_stb, rx_line, rx_vld, rx_busy, rx_start, tx_go, tx_busy, tx_done;
  logic [7:0] rx_byte, tx_byte;

  assign rx_line = pin_oe ? 1'b1 : ps_q[1];

  swu_baud #(.DIV_W(DIV_W)) u_baud (
    .clk(clk), .rst_n(rst_core_n), .div(baud_div), .tick(tick), .bit_stb(bit_stb));
  swu_rx u_rx (
    .clk(clk), .rst_n(rst_core_n), .tick(tick), .line(rx_line),
    .vld(rx_vld), .data(rx_byte), .busy(rx_busy), .start(rx_start));
  swu_tx u_tx (
    .clk(clk), .rst_n(rst_core_n), .tick(tick), .go(tx_go), .data(tx_byte),
    .txd(pin_out), .busy(tx_busy), .done(tx_done));

  node_st_t          st_q, st_d;
  logic [IDX_W-1:0]  idx_q, idx_d, txi_q, txi_d;
  logic [7:0]        crc_q, crc_d, adr_q, adr_d, cmd_q, cmd_d;
  logic [DATA_W-1:0] dat_q, dat_d, tx_sh;
  logic [DLY_W-1:0]  dly_q, dly_d;
  logic [GAP_W-1:0]  gap_q, gap_d;
  logic [IDL_W-1:0]  idle_q, idle_d;
  logic              rdy_q, rdy_d, lau_q, lau_d, wr_q, wr_d, rd_q, rd_d;

  always_comb begin
    tx_sh = dat_q << {txi_q - IDX_W'(3), 3'b000};
    if      (txi_q == IDX_W'(0))    tx_byte = SYNC_BYTE;
    else if (txi_q == IDX_W'(1))    tx_byte = MASTER_BYTE;
    else if (txi_q == IDX_W'(2))    tx_byte = {1'b0, cmd_q[6:0]};
    else if (txi_q == IDX_W'(LAST)) tx_byte = crc_q;
    else                            tx_byte = tx_sh[DATA_W-1 -: 8];
  end

  always_comb begin
    st_d = st_q; idx_d = idx_q; txi_d = txi_q; crc_d = crc_q;
    adr_d = adr_q; cmd_d = cmd_q; dat_d = dat_q; dly_d = dly_q;
    lau_d = lau_q; rdy_d = rdy_q; wr_d = 1'b0; rd_d = 1'b0; tx_go = 1'b0;
    gap_d = gap_q; idle_d = idle_q;

    if (rx_busy || !rx_line)                                 idle_d = '0;
    else if (bit_stb && idle_q != IDL_W'(IDLE_BITS))         idle_d = idle_q + 1'b1;
    if (idle_q == IDL_W'(IDLE_BITS))                         rdy_d  = 1'b1;
    if (rx_start)                                            gap_d  = '0;
    else if (bit_stb && gap_q <= GAP_W'(GAP_BITS))           gap_d  = gap_q + 1'b1;
    if (rd_q) dat_d = rd_data;

    case (st_q)
      N_RECV: begin
        if (gap_q > GAP_W'(GAP_BITS)) idx_d = '0;
        if (rx_vld && rdy_q) begin
          crc_d = crc8_lsb(crc_q, rx_byte);
          if (idx_q == IDX_W'(0)) begin
            crc_d = crc8_lsb(8'h00, rx_byte);
            if (rx_byte == SYNC_BYTE) idx_d = IDX_W'(1);
          end else if (idx_q == IDX_W'(1)) begin
            adr_d = rx_byte;
            idx_d = IDX_W'(2);
          end else if (idx_q == IDX_W'(2)) begin
            cmd_d = rx_byte;
            idx_d = IDX_W'(3);
          end else if (idx_q == IDX_W'(3) && !cmd_q[7]) begin
            idx_d = '0;
            if (rx_byte == crc_q && adr_q == node_addr) begin
              rd_d  = 1'b1;
              st_d  = N_WAIT;
              dly_d = '0;
            end
          end else if (idx_q == IDX_W'(LAST)) begin
            idx_d = '0;
            wr_d  = (rx_byte == crc_q) && (adr_q == node_addr);
          end else begin
            dat_d = {dat_q[DATA_W-9:0], rx_byte};
            idx_d = idx_q + 1'b1;
          end
        end
      end
      N_WAIT: if (bit_stb) begin
        if (dly_q == reply_delay) begin
          st_d  = N_SEND;
          txi_d = '0;
          crc_d = 8'h00;
          lau_d = 1'b0;
        end else begin
          dly_d = dly_q + 1'b1;
        end
      end
      N_SEND: begin
        if (!lau_q) begin
          tx_go = 1'b1;
          lau_d = 1'b1;
          if (txi_q != IDX_W'(LAST)) crc_d = crc8_lsb(crc_q, tx_byte);
        end else if (tx_done) begin
          lau_d = 1'b0;
          if (txi_q == IDX_W'(LAST)) st_d = N_RECV;
          else                       txi_d = txi_q + 1'b1;
        end
      end
      default: st_d = N_RECV;
    endcase
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      st_q <= N_RECV; idx_q <= '0; txi_q <= '0; crc_q <= '0;
      adr_q <= '0; cmd_q <= '0; dat_q <= '0; dly_q <= '0;
      gap_q <= '0; idle_q <= '0; rdy_q <= 1'b0; lau_q <= 1'b0;
      wr_q <= 1'b0; rd_q <= 1'b0;
    end else begin
      st_q <= st_d; idx_q <= idx_d; txi_q <= txi_d; crc_q <= crc_d;
      adr_q <= adr_d; cmd_q <= cmd_d; dat_q <= dat_d; dly_q <= dly_d;
      gap_q <= gap_d; idle_q <= idle_d; rdy_q <= rdy_d; lau_q <= lau_d;
      wr_q <= wr_d; rd_q <= rd_d;
    end
  end

  assign pin_oe   = (st_q == N_SEND);
  assign reg_addr = cmd_q[ADDR_W-1:0];
  assign wr_en    = wr_q;
  assign wr_data  = dat_q;
  assign rd_en    = rd_q;
endmodule

// File: rtl/swu_node_chk.sv
module swu_node_chk (
  input logic clk,
  input logic rst_n,
  input logic pin_oe,
  input logic pin_out,
  input logic wr_en,
  input logic rd_en
);
  AST_WR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) wr_en |=> !wr_en); // R2
  AST_RD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) rd_en |=> !rd_en); // R3
  AST_NO_DUAL_STROBE: assert property (@(posedge clk) disable iff (!rst_n) !(wr_en && rd_en)); // R2
  AST_LINE_HIGH_UNDRIVEN: assert property (@(posedge clk) disable iff (!rst_n) !pin_oe |-> pin_out); // R9
  AST_NO_STROBE_IN_REPLY: assert property (@(posedge clk) disable iff (!rst_n) pin_oe |-> (!wr_en && !rd_en)); // R9
  AST_PAUSE_BEFORE_REPLY: assert property (@(posedge clk) disable iff (!rst_n) rd_en |=> !pin_oe); // R8
endmodule

bind swu_node swu_node_chk u_chk (
  .clk(clk), .rst_n(rst_n), .pin_oe(pin_oe), .pin_out(pin_out),
  .wr_en(wr_en), .rd_en(rd_en));

// File: tb/swu_node_bench.sv
module swu_node_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] baud_div = 16'd1;
  logic [7:0]  node_addr = 8'h3C;
  logic [7:0]  reply_delay = 8'd8;
  logic [31:0] rd_data;
  logic        m_drv = 1'b1;
  logic        line, pin_out, pin_oe, wr_en, rd_en;
  logic [6:0]  reg_addr;
  logic [31:0] wr_data;

  int n_chk = 0, n_bad = 0, wr_cnt = 0, rd_cnt = 0;
  logic [6:0]  last_wa;
  logic [31:0] last_wd;

  always #2 clk = ~clk;

  assign line = pin_oe ? pin_out : m_drv;

  function automatic logic [31:0] model(input logic [6:0] a);
    return 32'h1357_9BDF ^ {4{1'b0, a}};
  endfunction
  assign rd_data = model(reg_addr);

  swu_node u_swu_node (
    .clk(clk), .rst_n(rst_n), .baud_div(baud_div), .node_addr(node_addr),
    .reply_delay(reply_delay), .rd_data(rd_data), .pin_in(line),
    .pin_out(pin_out), .pin_oe(pin_oe), .reg_addr(reg_addr), .wr_en(wr_en),
    .wr_data(wr_data), .rd_en(rd_en));

  always @(posedge clk) begin
    if (wr_en) begin
      wr_cnt  <= wr_cnt + 1;
      last_wa <= reg_addr;
      last_wd <= wr_data;
    end
    if (rd_en) rd_cnt <= rd_cnt + 1;
  end

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] crc_of(input logic [7:0] d [8], input int n);
    logic [7:0] c = 8'h00;
    for (int k = 0; k < n; k++)
      for (int i = 0; i < 8; i++)
        c = (c[7] ^ d[k][i]) ? ({c[6:0], 1'b0} ^ 8'h07) : {c[6:0], 1'b0};
    return c;
  endfunction

  task automatic put_byte(input logic [7:0] b);
    m_drv = 1'b0;
    repeat (16) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      m_drv = b[i];
      repeat (16) @(negedge clk);
    end
    m_drv = 1'b1;
    repeat (16) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] d [8], input int first, input int last);
    for (int k = first; k <= last; k++) put_byte(d[k]);
  endtask

  task automatic mk_write(input logic [7:0] sync, input logic [7:0] node, input logic [6:0] a,
                          input logic [31:0] v, input logic [7:0] crc_x, output logic [7:0] d [8]);
    d[0] = sync; d[1] = node; d[2] = {1'b1, a};
    d[3] = v[31:24]; d[4] = v[23:16]; d[5] = v[15:8]; d[6] = v[7:0];
    d[7] = crc_of(d, 7) ^ crc_x;
  endtask

  task automatic do_write(input logic [7:0] sync, input logic [7:0] node, input logic [6:0] a,
                          input logic [31:0] v, input logic [7:0] crc_x, input bit expect_wr,
                          input string req);
    logic [7:0] d [8];
    int w0;
    w0 = wr_cnt;
    mk_write(sync, node, a, v, crc_x, d);
    send(d, 0, 7);
    repeat (4) @(negedge clk);
    chk(req, "write strobe count", 64'(wr_cnt - w0), expect_wr ? 64'd1 : 64'd0);
    if (expect_wr) begin
      chk(req, "write address", 64'(last_wa), 64'(a));
      chk(req, "write data", 64'(last_wd), 64'(v));
    end
  endtask

  task automatic wait_low(output bit ok);
    ok = 1'b0;
    for (int k = 0; k < 2000; k++) begin
      if (line == 1'b0) begin ok = 1'b1; break; end
      @(negedge clk);
    end
  endtask

  task automatic do_read(input logic [7:0] node, input logic [6:0] a, input bit expect_rep);
    logic [7:0] d [8], e [8], r;
    int r0, cyc;
    bit ok, oe_ok, saw_low;
    r0 = rd_cnt;
    d[0] = 8'h05; d[1] = node; d[2] = {1'b0, a};
    d[3] = crc_of(d, 3); d[4] = 0; d[5] = 0; d[6] = 0; d[7] = 0;
    send(d, 0, 3);
    if (!expect_rep) begin
      saw_low = 1'b0;
      for (int k = 0; k < int'(reply_delay) * 16 + 400; k++) begin
        if (line == 1'b0 || pin_oe) saw_low = 1'b1;
        @(negedge clk);
      end
      chk("R5", "reply activity for foreign read", 64'(saw_low), 64'd0);
      chk("R5", "read strobe count", 64'(rd_cnt - r0), 64'd0);
      return;
    end
    cyc = 0;
    while (line == 1'b1 && cyc < 5000) begin @(negedge clk); cyc++; end
    chk("R8", "reply start inside delay window",
        64'(cyc >= int'(reply_delay) * 16 - 8 && cyc <= int'(reply_delay) * 16 + 24), 64'd1);
    chk("R3", "read strobe count", 64'(rd_cnt - r0), 64'd1);
    e[0] = 8'h05; e[1] = 8'hFF; e[2] = {1'b0, a};
    {e[3], e[4], e[5], e[6]} = model(a);
    e[7] = crc_of(e, 7);
    oe_ok = 1'b1;
    for (int k = 0; k < 8; k++) begin
      wait_low(ok);
      repeat (8) @(negedge clk);
      oe_ok &= pin_oe;
      for (int i = 0; i < 8; i++) begin
        repeat (16) @(negedge clk);
        r[i] = line;
        oe_ok &= pin_oe;
      end
      repeat (16) @(negedge clk);
      ok &= line;
      chk(k == 7 ? "R4" : "R3", $sformatf("reply byte %0d", k), 64'(r), 64'(e[k]));
      chk("R9", $sformatf("frame of reply byte %0d", k), 64'(ok), 64'd1);
    end
    chk("R9", "enable held through reply", 64'(oe_ok), 64'd1);
    repeat (12) @(negedge clk);
    chk("R9", "enable released after reply", 64'(pin_oe), 64'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] d [8];
    repeat (5) @(negedge clk);
    chk("R9", "reset enable", 64'(pin_oe), 64'd0);
    chk("R9", "reset line level", 64'(pin_out), 64'd1);
    chk("R2", "reset strobes", 64'({wr_en, rd_en}), 64'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R7: traffic right after reset is ignored
    do_write(8'h05, 8'h3C, 7'h11, 32'hDEAD_BEEF, 8'h00, 1'b0, "R7");
    repeat (16 * 14) @(negedge clk);
    // R2 / R4: sweep of addresses and data patterns
    for (int k = 0; k < 8; k++)
      do_write(8'h05, 8'h3C, 7'(k * 17 + (k == 7 ? 8 : 0)),
               32'h8000_0001 ^ (32'h0F1E_2D3C * k), 8'h00, 1'b1, "R2");
    do_write(8'h05, 8'h3C, 7'h22, 32'h1234_5678, 8'h01, 1'b0, "R4");
    do_write(8'h05, 8'h3D, 7'h22, 32'h1234_5678, 8'h00, 1'b0, "R5");
    do_write(8'h15, 8'h3C, 7'h22, 32'h1234_5678, 8'h00, 1'b0, "R1");
    // R6: long gap restarts assembly
    mk_write(8'h05, 8'h3C, 7'h33, 32'hA1B2_C3D4, 8'h00, d);
    send(d, 0, 1);
    repeat (16 * 70) @(negedge clk);
    do_write(8'h05, 8'h3C, 7'h34, 32'h0BAD_F00D, 8'h00, 1'b1, "R6");
    // R6: short gap keeps the partial datagram
    mk_write(8'h05, 8'h3C, 7'h44, 32'h7766_5544, 8'h00, d);
    send(d, 0, 2);
    repeat (16 * 40) @(negedge clk);
    begin
      int w0;
      w0 = wr_cnt;
      send(d, 3, 7);
      repeat (4) @(negedge clk);
      chk("R6", "write after short gap", 64'(wr_cnt - w0), 64'd1);
      chk("R6", "address after short gap", 64'(last_wa), 64'h44);
    end
    // R3 / R8 / R9: reads with two delays
    reply_delay = 8'd8;
    do_read(8'h3C, 7'h05, 1'b1);
    do_read(8'h3C, 7'h7F, 1'b1);
    reply_delay = 8'd2;
    do_read(8'h3C, 7'h00, 1'b1);
    do_read(8'h3C, 7'h5A, 1'b1);
    do_read(8'h3B, 7'h5A, 1'b0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule